// File: doc/BRIEF.md
# AC-link input frame serializer

This block is the codec end of the serial return path on an AC97-style link. It runs on the link bit clock and looks for a low-to-high step on the frame-sync line, sampling that line on falling edges. On the rising edge after the step is seen, it loads a complete 256-bit frame and starts shifting it out on its serial output, most significant bit first. It then drives one bit per rising edge, so that the controller can sample each bit on the falling edge that follows.

The frame opens with a 16-bit tag slot: a codec-ready bit, then one valid bit for each data slot. Twelve 20-bit data slots follow. Slot 1 returns the index of the register being read, together with the variable-rate slot-request field. Slot 2 returns the 16-bit read data. Slots 3 and 4 carry the left and right ADC samples. Slots 5 to 12 are always zero. Every position that holds no valid data is driven as 0. All slot contents are captured at the instant a frame is loaded, so an input that changes while the frame is being sent cannot corrupt that frame.

Top module: `ac_in_serializer`

## Requirements
- R1: `sdin` is 0 while `rst` is high, and it stays 0 whenever no frame is being shifted out.
- R2: A low-to-high step on `sync` is sampled on a falling edge of `bit_clk`. On the next rising edge, `sdin` drives frame bit 0, which is the codec-ready bit. Each later rising edge drives the next bit, for 256 bits in total. `sdin` is still 0 on the falling edge at which the step is first seen.
- R3: The tag slot is frame bits 0 to 15. Bit 0 is `codec_ready`. Bits 1 to 4 are `slot_valid[0]` to `slot_valid[3]`, which are the valid tags of slots 1 to 4. Bits 5 to 15 are 0.
- R4: Slot 1 is frame bits 16 to 35, sent from slot bit 19 down to slot bit 0. Slot bit 19 is 0. Bits 18:12 carry `reg_index` when `slot_valid[0]` is 1 and are 0 otherwise. Bits 11:2 carry the slot-request field. Bits 1:0 are 0.
- R5: When `vra_en` is 1, slot 1 bits 11:2 carry `slot_req` whatever the value of `slot_valid[0]`. When `vra_en` is 0, those bits are 0.
- R6: Slot 2 is frame bits 36 to 55. Its bits 19:4 carry `reg_rdata` when `slot_valid[1]` is 1, and its bits 3:0 are 0. When `slot_valid[1]` is 0, the whole slot is 0.
- R7: Slot 3 (frame bits 56 to 75) and slot 4 (frame bits 76 to 95) carry `adc_left` and `adc_right`, MSB first from slot bit 19. The positions below the sample width are 0. A slot whose valid tag (`slot_valid[2]` or `slot_valid[3]`) is 0 is all 0.
- R8: Slots 5 to 12 (frame bits 96 to 255) are always 0.
- R9: All slot contents are taken from the inputs at the rising edge that drives frame bit 0. Changes to the inputs after that edge do not alter the frame.
- R10: A new `sync` step raised on the rising edge that drives bit 255 starts the next frame directly after it, with no idle bit between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame sync from the controller |
| codec_ready | input | 1 | Codec-ready flag for the tag slot |
| slot_valid | input | 4 | Valid tags for slots 1 to 4 (bit 0 is slot 1) |
| vra_en | input | 1 | Variable-rate mode; the slot-request field is driven while this is 1 |
| reg_index | input | 7 | Index of the register being returned |
| slot_req | input | 10 | Variable-rate slot-request field |
| reg_rdata | input | 16 | Register read data |
| adc_left | input | ADC_W | Left ADC sample |
| adc_right | input | ADC_W | Right ADC sample |
| sdin | output | 1 | Serial frame output, changes on rising edges |

## Verification
In one rising edge, the block can both shift out bit 255 of the current frame and load the next frame. The bench makes this happen by raising `sync` on the rising edge that drives bit 255. It then records the output on every falling edge across both frames and expects an unbroken 512-bit stream. The same load edge also has to capture every input on its own. To test this, the bench changes all the inputs a few bits into a frame and checks that the frame still matches the values present at the load.

// File: rtl/ac_in_pkg.sv
package ac_in_pkg;

    localparam int SLOT_W     = 20;
    localparam int TAG_W      = 16;
    localparam int NUM_SLOTS  = 12;
    localparam int USED_SLOTS = 4;
    localparam int FRAME_W    = TAG_W + SLOT_W * NUM_SLOTS;
    localparam int IDX_W      = 7;
    localparam int REQ_W      = 10;
    localparam int RD_W       = 16;

    typedef logic [SLOT_W-1:0]  slot_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic [1:0] {
        SK_STAT_ADDR,
        SK_STAT_DATA,
        SK_PCM,
        SK_EMPTY
    } slot_kind_e;

    typedef struct packed {
        logic                  ready;
        logic [USED_SLOTS-1:0] valid;
        logic                  vra;
        logic [IDX_W-1:0]      index;
        logic [REQ_W-1:0]      req;
        logic [RD_W-1:0]       rdata;
    } status_in_t;

    function automatic slot_kind_e kind_of(input int s);
        case (s)
            1:       return SK_STAT_ADDR;
            2:       return SK_STAT_DATA;
            3, 4:    return SK_PCM;
            default: return SK_EMPTY;
        endcase
    endfunction

    // Slot 1: bit 19 zero, index at 18:12, request field at 11:2, 1:0 zero.
    function automatic slot_t build_addr_slot(input status_in_t st);
        slot_t s;
        s = '0;
        if (st.valid[0]) s[18:12] = st.index;
        if (st.vra)      s[11:2]  = st.req;
        return s;
    endfunction

    // Slot 2: data at 19:4, zero when tagged invalid.
    function automatic slot_t build_data_slot(input status_in_t st);
        slot_t s;
        s = '0;
        if (st.valid[1]) s[19:4] = st.rdata;
        return s;
    endfunction

endpackage

// File: rtl/ac_in_sync_detect.sv
module ac_in_sync_detect (
    input  logic bit_clk,
    input  logic rst,
    input  logic sync,
    output logic frame_start
);
    logic sync_now;
    logic sync_prev;

    // Sync is launched on rising edges, so it is sampled on falling edges.
    always_ff @(negedge bit_clk) begin
        if (rst) begin
            sync_now  <= 1'b0;
            sync_prev <= 1'b0;
        end else begin
            sync_now  <= sync;
            sync_prev <= sync_now;
        end
    end

    assign frame_start = sync_now & ~sync_prev;
endmodule

// File: rtl/ac_in_frame_builder.sv
module ac_in_frame_builder
    import ac_in_pkg::*;
#(
    parameter int ADC_W = 18
) (
    input  status_in_t       st,
    input  logic [ADC_W-1:0] adc_left,
    input  logic [ADC_W-1:0] adc_right,
    output frame_t           frame
);
    localparam int PAD_W = SLOT_W - ADC_W;

    logic [TAG_W-1:0] tag;
    slot_t            slots [1:NUM_SLOTS];

    always_comb begin
        tag          = '0;
        tag[TAG_W-1] = st.ready;
        for (int k = 0; k < USED_SLOTS; k++) begin
            tag[TAG_W-2-k] = st.valid[k];
        end
    end

    assign frame[FRAME_W-1 -: TAG_W] = tag;

    for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slot
        localparam slot_kind_e KIND = kind_of(s);
        if (KIND == SK_STAT_ADDR) begin : g_addr
            assign slots[s] = build_addr_slot(st);
        end else if (KIND == SK_STAT_DATA) begin : g_data
            assign slots[s] = build_data_slot(st);
        end else if (KIND == SK_PCM) begin : g_pcm
            logic [ADC_W-1:0] sample;
            assign sample   = (s == 3) ? adc_left : adc_right;
            assign slots[s] = st.valid[s-1] ? (slot_t'(sample) << PAD_W) : '0;
        end else begin : g_empty
            assign slots[s] = '0;
        end
        assign frame[FRAME_W-TAG_W-1-SLOT_W*(s-1) -: SLOT_W] = slots[s];
    end
endmodule

// File: rtl/ac_in_shifter.sv
module ac_in_shifter
    import ac_in_pkg::*;
(
    input  logic   bit_clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame,
    output logic   sdin
);
    frame_t shreg;

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            shreg <= '0;
            sdin  <= 1'b0;
        end else if (load) begin
            sdin  <= frame[FRAME_W-1];
            shreg <= {frame[FRAME_W-2:0], 1'b0};
        end else begin
            sdin  <= shreg[FRAME_W-1];
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/ac_in_serializer.sv
module ac_in_serializer
    import ac_in_pkg::*;
#(
    parameter int ADC_W = 18
) (
    input  logic                  bit_clk,
    input  logic                  rst,
    input  logic                  sync,
    input  logic                  codec_ready,
    input  logic [USED_SLOTS-1:0] slot_valid,
    input  logic                  vra_en,
    input  logic [IDX_W-1:0]      reg_index,
    input  logic [REQ_W-1:0]      slot_req,
    input  logic [RD_W-1:0]       reg_rdata,
    input  logic [ADC_W-1:0]      adc_left,
    input  logic [ADC_W-1:0]      adc_right,
    output logic                  sdin
);
    logic       frame_start;
    status_in_t st;
    frame_t     frame;

    assign st.ready = codec_ready;
    assign st.valid = slot_valid;
    assign st.vra   = vra_en;
    assign st.index = reg_index;
    assign st.req   = slot_req;
    assign st.rdata = reg_rdata;

    ac_in_sync_detect u_sync (
        .bit_clk     (bit_clk),
        .rst         (rst),
        .sync        (sync),
        .frame_start (frame_start)
    );

    ac_in_frame_builder #(.ADC_W(ADC_W)) u_build (
        .st        (st),
        .adc_left  (adc_left),
        .adc_right (adc_right),
        .frame     (frame)
    );

    ac_in_shifter u_shift (
        .bit_clk (bit_clk),
        .rst     (rst),
        .load    (frame_start),
        .frame   (frame),
        .sdin    (sdin)
    );
endmodule

// File: rtl/ac_in_serializer_chk.sv
module ac_in_serializer_chk
    import ac_in_pkg::*;
#(
    parameter int ADC_W = 18
) (
    input logic bit_clk,
    input logic rst,
    input logic frame_start,
    input logic codec_ready,
    input logic sdin
);
    // Independent bit-position tracker: cpos is the frame bit now on sdin.
    logic [7:0] cpos;
    logic       act;

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            act  <= 1'b0;
            cpos <= '0;
        end else if (frame_start) begin
            act  <= 1'b1;
            cpos <= '0;
        end else if (act) begin
            if (cpos == 8'(FRAME_W - 1)) act <= 1'b0;
            else                         cpos <= cpos + 8'd1;
        end
    end

    p_idle_zero_r1: assert property (@(posedge bit_clk) disable iff (rst)
        (!act && !frame_start) |=> !sdin);

    p_first_bit_r2: assert property (@(posedge bit_clk) disable iff (rst)
        frame_start |=> (sdin == $past(codec_ready)));

    p_tag_pad_r3: assert property (@(posedge bit_clk) disable iff (rst)
        (act && cpos >= 8'd5 && cpos <= 8'd15) |-> !sdin);

    p_addr_pad_r4: assert property (@(posedge bit_clk) disable iff (rst)
        (act && (cpos == 8'd16 || cpos == 8'd34 || cpos == 8'd35)) |-> !sdin);

    p_data_pad_r6: assert property (@(posedge bit_clk) disable iff (rst)
        (act && cpos >= 8'd52 && cpos <= 8'd55) |-> !sdin);

    p_adc_pad_r7: assert property (@(posedge bit_clk) disable iff (rst)
        (act && ((int'(cpos) >= 56 + ADC_W && cpos < 8'd76) ||
                 (int'(cpos) >= 76 + ADC_W && cpos < 8'd96))) |-> !sdin);

    p_unused_slots_r8: assert property (@(posedge bit_clk) disable iff (rst)
        (act && cpos >= 8'd96) |-> !sdin);
endmodule

bind ac_in_serializer ac_in_serializer_chk #(.ADC_W(ADC_W)) u_chk (
    .bit_clk     (bit_clk),
    .rst         (rst),
    .frame_start (frame_start),
    .codec_ready (codec_ready),
    .sdin        (sdin)
);

// File: tb/ac_in_serializer_tb.sv
module ac_in_serializer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADC_W      = 18;

    logic        bit_clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync = 1'b0;
    logic        codec_ready = 1'b0;
    logic [3:0]  slot_valid = '0;
    logic        vra_en = 1'b0;
    logic [6:0]  reg_index = '0;
    logic [9:0]  slot_req = '0;
    logic [15:0] reg_rdata = '0;
    logic [ADC_W-1:0] adc_left = '0;
    logic [ADC_W-1:0] adc_right = '0;
    logic        sdin;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

    ac_in_serializer #(.ADC_W(ADC_W)) u_dut (
        .bit_clk(bit_clk), .rst(rst), .sync(sync), .codec_ready(codec_ready),
        .slot_valid(slot_valid), .vra_en(vra_en), .reg_index(reg_index),
        .slot_req(slot_req), .reg_rdata(reg_rdata), .adc_left(adc_left),
        .adc_right(adc_right), .sdin(sdin)
    );

    task automatic check(input string req, input string what,
                         input logic [255:0] got, input logic [255:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Expected frame written from the requirements; bit 255 goes out first.
    function automatic logic [255:0] expect_frame();
        logic [255:0] f;
        f = '0;
        f[255] = codec_ready;
        for (int k = 0; k < 4; k++) f[254-k] = slot_valid[k];
        if (slot_valid[0]) f[238 -: 7]  = reg_index;   // slot 1 bits 18:12
        if (vra_en)        f[231 -: 10] = slot_req;    // slot 1 bits 11:2
        if (slot_valid[1]) f[219 -: 16] = reg_rdata;   // slot 2 bits 19:4
        if (slot_valid[2]) f[199 -: ADC_W] = adc_left; // slot 3
        if (slot_valid[3]) f[179 -: ADC_W] = adc_right;// slot 4
        return f;
    endfunction

    task automatic set_inputs(input logic rdy, input logic [3:0] v, input logic vra,
                              input logic [6:0] idx, input logic [9:0] req,
                              input logic [15:0] rd, input logic [ADC_W-1:0] l,
                              input logic [ADC_W-1:0] r);
        codec_ready = rdy; slot_valid = v; vra_en = vra; reg_index = idx;
        slot_req = req; reg_rdata = rd; adc_left = l; adc_right = r;
    endtask

    // Raise sync on a rising edge; at the detecting falling edge sdin is still idle.
    task automatic raise_sync();
        @(posedge bit_clk); #1 sync = 1'b1;
        @(negedge bit_clk); #1;
        check("R2", "idle at detect edge", 256'(sdin), 256'd0);
    endtask

    task automatic capture(output logic [255:0] f, input bit mutate, input bit chain);
        f = '0;
        @(posedge bit_clk);
        for (int i = 0; i < 256; i++) begin
            if (i == 255 && chain) begin
                @(posedge bit_clk); #1 sync = 1'b1;
            end
            @(negedge bit_clk); #1;
            f[255-i] = sdin;
            if (i == 15) sync = 1'b0;
            if (i == 3 && mutate)
                set_inputs(1'b0, 4'b0000, 1'b0, 7'h55, 10'h2AA, 16'hFFFF, '1, '1);
        end
    endtask

    task automatic compare_frame(input string tag, input logic [255:0] got,
                                 input logic [255:0] exp);
        check({"R3 R2 ", tag}, "tag slot", 256'(got[255:240]), 256'(exp[255:240]));
        check({"R4 R5 ", tag}, "slot 1",  256'(got[239:220]), 256'(exp[239:220]));
        check({"R6 ", tag}, "slot 2",     256'(got[219:200]), 256'(exp[219:200]));
        check({"R7 ", tag}, "slot 3",     256'(got[199:180]), 256'(exp[199:180]));
        check({"R7 ", tag}, "slot 4",     256'(got[179:160]), 256'(exp[179:160]));
        check({"R8 ", tag}, "slots 5-12", 256'(got[159:0]),   256'(exp[159:0]));
    endtask

    task automatic idle_after(input string tag);
        for (int i = 0; i < 4; i++) begin
            @(negedge bit_clk); #1;
            check({"R1 ", tag}, "idle after frame", 256'(sdin), 256'd0);
        end
    endtask

    task automatic t_reset();
        repeat (3) begin
            @(negedge bit_clk); #1;
            check("R1", "during reset", 256'(sdin), 256'd0);
        end
        @(posedge bit_clk); #1 rst = 1'b0;
        idle_after("post reset");
    endtask

    task automatic t_full_valid();
        logic [255:0] got, exp;
        set_inputs(1'b1, 4'b1111, 1'b1, 7'h5A, 10'h3C5, 16'hBEEF, 18'h2ABCD, 18'h15432);
        exp = expect_frame();
        raise_sync();
        capture(got, 1'b0, 1'b0);
        compare_frame("all valid", got, exp);
        idle_after("all valid");
    endtask

    task automatic t_vra_req_untagged_r5();
        logic [255:0] got, exp;
        set_inputs(1'b1, 4'b1100, 1'b1, 7'h7F, 10'h2B7, 16'h1234, 18'h3FFFF, 18'h00001);
        exp = expect_frame();
        raise_sync();
        capture(got, 1'b0, 1'b0);
        compare_frame("slot1/2 invalid vra on", got, exp);
    endtask

    task automatic t_vra_off();
        logic [255:0] got, exp;
        set_inputs(1'b0, 4'b0001, 1'b0, 7'h23, 10'h3FF, 16'hA5A5, 18'h12345, 18'h23456);
        exp = expect_frame();
        raise_sync();
        capture(got, 1'b0, 1'b0);
        compare_frame("vra off", got, exp);
        check("R5", "request field zero with vra off", 256'(got[231 -: 10]), 256'd0);
    endtask

    task automatic t_latch_r9();
        logic [255:0] got, exp;
        set_inputs(1'b1, 4'b1011, 1'b1, 7'h11, 10'h155, 16'h0F0F, 18'h0ABCD, 18'h3C3C3);
        exp = expect_frame();
        raise_sync();
        capture(got, 1'b1, 1'b0);
        check("R9", "frame unchanged by mid-frame inputs", got, exp);
    endtask

    task automatic t_back_to_back_r10();
        logic [255:0] a, b, ea, eb;
        set_inputs(1'b1, 4'b0110, 1'b1, 7'h01, 10'h001, 16'h8001, 18'h20001, 18'h10002);
        ea = expect_frame();
        raise_sync();
        capture(a, 1'b0, 1'b1);
        set_inputs(1'b1, 4'b1001, 1'b1, 7'h40, 10'h200, 16'h7FFE, 18'h1FFFE, 18'h2FFFD);
        eb = expect_frame();
        capture(b, 1'b0, 1'b0);
        check("R10", "first of back-to-back frames", a, ea);
        check("R10", "second of back-to-back frames", b, eb);
        idle_after("back to back");
    endtask

    initial begin
        t_reset();
        t_full_valid();
        t_vra_req_untagged_r5();
        t_vra_off();
        t_latch_r9();
        t_back_to_back_r10();
        repeat (4) @(posedge bit_clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge bit_clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule